// File: doc/BRIEF.md
# Retriggerable Trigger Pulse Stretcher

This block turns a noisy, asynchronous trigger line into one clean pulse per trigger event for a downstream delay generator. The raw line is brought into the clock domain through a flop chain. The stretched output rises on the first leading edge it sees. It then stays high for as long as the input is high, and for a fixed number of hold-off cycles after the input's latest trailing edge. Every trailing edge reloads the hold-off timer. Leading edges never touch the timer. Because of this, re-bounces and glitches that return within the hold-off window merge into the pulse that is already running.

After reset the block is unarmed. The first complete pulse it sees, from the trigger line or from the synchronous soft trigger input, is consumed to arm it and produces no output. Software normally issues a single soft trigger for this. From then on the block stays armed until the next reset.

Top module: `trig_stretcher`

## Requirements
- R1: While reset is asserted and in the first sample after it, `stretch_out` and `armed` are both 0.
- R2: With the block armed and idle, a rising edge on `trig_in` that is set up before clock edge k makes `stretch_out` high after clock edge k+2. The synchroniser accounts for two of those cycles and the output register for one.
- R3: A single clean input pulse that is high for W cycles, with idle time around it, gives exactly one output pulse of W + HOLD_CYCLES cycles.
- R4: Two input pulses separated by a low gap of G cycles, where 1 <= G <= HOLD_CYCLES, give exactly one output pulse. That pulse ends HOLD_CYCLES cycles after the second trailing edge, so it is W1 + G + W2 + HOLD_CYCLES cycles long.
- R5: A low gap of HOLD_CYCLES + 1 cycles or more gives two separate output pulses, each of its input width plus HOLD_CYCLES.
- R6: Only trailing edges load the hold-off timer. For an input pulse longer than the hold-off, the output still lasts W + HOLD_CYCLES cycles, with no early drop while the input is high.
- R7: When unarmed, the first input pulse produces no output at all. `armed` goes to 1 three clock edges after the input's trailing edge enters the synchroniser.
- R8: `soft_trig` is ORed with the synchronised input. A one-cycle soft trigger arms an unarmed block one edge after it ends. On an armed block it gives an output pulse of HOLD_CYCLES + 1 cycles that starts on the next clock edge.
- R9: `armed` stays 1 until reset. Reset in the middle of an output pulse drops `stretch_out`, clears the timer and disarms the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Raw asynchronous trigger line |
| soft_trig | input | 1 | Synchronous soft trigger, ORed after the synchroniser |
| stretch_out | output | 1 | Registered stretched trigger pulse |
| armed | output | 1 | High once the arming pulse has been consumed |

## Verification
Each result has a fixed delay from its stimulus:
- The output rises three edges after `trig_in` rises.
- The output falls HOLD_CYCLES + 3 edges after `trig_in` falls.
- `armed` rises three edges after the arming trailing edge.
- For `soft_trig`, which skips the synchroniser, both the output and `armed` respond one edge later.

The bench drives inputs on falling clock edges and samples on the same falling edges before driving. It records the index of the first high sample, the number of rising transitions and the total high samples over a window long enough for the tail to drain. All of these are compared with values computed from W1, G, W2 and HOLD_CYCLES.

// File: rtl/stretch_pkg.sv
package stretch_pkg;
  // Edge events of the qualified trigger level.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/stretch_sync.sv
module stretch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stretch_edge.sv
module stretch_edge
  import stretch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     level,
  output edge_ev_t ev
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  always_comb begin
    ev.rise = level & ~level_q;
    ev.fall = ~level & level_q;
  end
endmodule

// File: rtl/stretch_holdoff.sv
module stretch_holdoff #(
  parameter int HOLD = 8,
  localparam int CW = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic          busy_next,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (load)              cnt_d = CW'(HOLD);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    else                   cnt_d = '0;
    busy_next = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R4: every trailing edge reloads the full hold-off
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == CW'(HOLD)));

  // R3: without a reload the timer only counts down
  assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(HOLD));
endmodule

// File: rtl/trig_stretcher.sv
module trig_stretcher
  import stretch_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic soft_trig,
  output logic stretch_out,
  output logic armed
);
  logic          sync_q;
  logic          eff;
  edge_ev_t      ev;
  logic          load;
  logic          busy_next;
  logic [CW-1:0] cnt_q;

  stretch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(trig_in), .q(sync_q)
  );

  assign eff = sync_q | soft_trig;

  stretch_edge u_edge (
    .clk(clk), .rst(rst), .level(eff), .ev(ev)
  );

  // Timer runs only on trailing edges seen while armed.
  assign load = ev.fall & armed;

  stretch_holdoff #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst(rst), .load(load), .busy_next(busy_next), .cnt_q(cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      stretch_out <= 1'b0;
    end else begin
      if (ev.fall) armed <= 1'b1;
      stretch_out <= armed & (eff | busy_next);
    end
  end

  // R7: nothing leaves the block while unarmed
  assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !stretch_out);

  // R9: arming is sticky until reset
  assert_armed_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$fell(armed));

  // R2: an armed leading edge raises the output on the next edge
  assert_rise_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (ev.rise && armed) |=> stretch_out);

  // R6: the output only drops with the input low and the timer spent
  assert_drop_only_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(stretch_out) |-> (!$past(eff) && $past(cnt_q) <= CW'(1)));

  // R4: a trailing edge while armed keeps the output high
  assert_tail_held_R4: assert property (@(posedge clk) disable iff (rst)
    (ev.fall && armed) |=> stretch_out);
endmodule

// File: tb/trig_stretcher_tb.sv
module trig_stretcher_tb;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0;
  logic soft_trig = 1'b0;
  logic stretch_out;
  logic armed;

  int checks = 0;
  int errors = 0;

  trig_stretcher #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .soft_trig(soft_trig),
    .stretch_out(stretch_out), .armed(armed)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; trig_in = 1'b0; soft_trig = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive high W1, low G, high W2 on trig_in; sample before each drive.
  task automatic pattern(input int w1, input int g, input int w2,
                         output int first, output int rises, output int highs);
    int total = w1 + g + w2 + HOLD + 10;
    logic prev = 1'b0;
    first = -1; rises = 0; highs = 0;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (stretch_out) begin
        highs++;
        if (first < 0) first = i;
      end
      if (stretch_out && !prev) rises++;
      prev = stretch_out;
      trig_in = (i < w1) || (i >= w1 + g && i < w1 + g + w2);
    end
  endtask

  initial begin
    #500000;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    errors++; checks++;
    summary();
    $finish;
  end

  initial begin
    int first, rises, highs;
    logic saw_high;

    // R1: reset state
    @(negedge clk);
    check(stretch_out == 1'b0, "R1 out in reset", stretch_out, 0);
    check(armed == 1'b0, "R1 armed in reset", armed, 0);
    do_reset();
    @(negedge clk);
    check(stretch_out == 1'b0 && armed == 1'b0, "R1 after reset",
          {stretch_out, armed}, 0);

    // R7: first trig pulse is swallowed and arms the block
    saw_high = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (stretch_out) saw_high = 1'b1;
      if (i == 5) check(armed == 1'b0, "R7 armed before", armed, 0);
      if (i == 6) check(armed == 1'b1, "R7 armed after", armed, 1);
      trig_in = (i < 3);
    end
    check(saw_high == 1'b0, "R7 swallowed", saw_high, 0);

    // R2 R3 R4 R5 R6 sweep
    for (int w1i = 0; w1i < 4; w1i++) begin
      for (int g = 1; g <= HOLD + 2; g++) begin
        for (int w2i = 0; w2i < 2; w2i++) begin
          int w1 = (w1i == 0) ? 1 : (w1i == 1) ? 2 : (w1i == 2) ? 5 : HOLD + 4;
          int w2 = (w2i == 0) ? 1 : 3;
          pattern(w1, g, w2, first, rises, highs);
          check(first == 3, "R2 rise latency", first, 3);
          if (g <= HOLD) begin
            check(rises == 1, "R4 merged count", rises, 1);
            check(highs == w1 + g + w2 + HOLD, "R4 merged width",
                  highs, w1 + g + w2 + HOLD);
          end else begin
            check(rises == 2, "R5 split count", rises, 2);
            check(highs == w1 + w2 + 2 * HOLD, "R5 split width",
                  highs, w1 + w2 + 2 * HOLD);
          end
        end
      end
    end

    // R3 and R6: single pulses, short and long
    for (int w = 1; w <= HOLD + 6; w++) begin
      pattern(w, 0, 0, first, rises, highs);
      check(rises == 1, w > HOLD ? "R6 long count" : "R3 single count", rises, 1);
      check(highs == w + HOLD, w > HOLD ? "R6 long width" : "R3 single width",
            highs, w + HOLD);
    end

    // R9: armed remained set through the sweep
    check(armed == 1'b1, "R9 sticky", armed, 1);

    // R9: reset mid-pulse
    @(negedge clk); trig_in = 1'b1;
    repeat (5) @(negedge clk);
    check(stretch_out == 1'b1, "R9 pulse running", stretch_out, 1);
    rst = 1'b1;
    @(negedge clk);
    check(stretch_out == 1'b0 && armed == 1'b0, "R9 reset clears",
          {stretch_out, armed}, 0);
    trig_in = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);

    // R8: soft trigger arms
    do_reset();
    @(negedge clk);
    soft_trig = 1'b1;
    @(negedge clk);
    soft_trig = 1'b0;
    check(armed == 1'b0 && stretch_out == 1'b0, "R8 not yet armed",
          {stretch_out, armed}, 0);
    @(negedge clk);
    check(armed == 1'b1, "R8 soft arm", armed, 1);
    check(stretch_out == 1'b0, "R8 arm swallowed", stretch_out, 0);
    repeat (3) @(negedge clk);

    // R8: soft trigger pulse when armed
    first = -1; highs = 0;
    for (int i = 0; i < HOLD + 8; i++) begin
      @(negedge clk);
      if (stretch_out) begin
        highs++;
        if (first < 0) first = i;
      end
      soft_trig = (i == 0);
    end
    check(first == 1, "R8 soft latency", first, 1);
    check(highs == HOLD + 1, "R8 soft width", highs, HOLD + 1);

    summary();
    $finish;
  end
endmodule